// File: doc/BRIEF.md
# T1 Transmit Frame Timing Generator

This block generates the transmit-side timing strobes for a 24-channel T1 stream. A single 1.544 MHz bit clock drives it. It tracks the position of the current bit inside the 193-bit frame. Each frame starts with a framing bit, followed by 24 channels of 8 bits, most significant bit first. It also tracks which frame of the multiframe is current. The multiframe is 12 frames long in D4 mode and 24 frames long in ESF mode.

One shared counter feeds four outputs:

- **Channel LSB strobe:** high during the last bit of every channel.
- **Channel block output:** follows a software-supplied 24-bit mask, channel by channel.
- **Sync pulse:** marks either every frame or only the first frame of the multiframe. In per-frame mode it can be stretched on signaling frames.
- **Data-link demand clock:** requests one data-link bit for each frame that carries one.

Downstream formatters use these strobes to place channel data, framing and link bits. Line coding, elastic stores, signaling insertion and HDLC are handled elsewhere.

Top module: `t1_tx_timing`

## Requirements
- R1: After reset is released, the first bit period is the framing bit of frame 1. In that period `chan_clk_o` and `chan_blk_o` are 0, and `sync_o` is 1 in per-frame mode.
- R2: Framing bits repeat every 193 clock cycles. Bit position 0 is the framing bit, and positions 1..192 carry channels 1..24 with 8 bits each.
- R3: `chan_clk_o` is 1 exactly at bit positions 8, 16, …, 192, which are the last bits of channels 1..24. It is 0 at every other position.
- R4: `chan_blk_o` equals `chan_mask_i[k]` during all 8 bits of channel k+1 (bit 0 of the mask is channel 1). It is 0 during the framing bit.
- R5: With `mf_sync_i`=0 and `dbl_wide_i`=0, `sync_o` is 1 only during the framing bit of every frame.
- R6: With `mf_sync_i`=1, `sync_o` is 1 only during the framing bit of frame 1 of the multiframe. The multiframe is 12 frames when `esf_i`=0 and 24 frames when `esf_i`=1. In this mode `dbl_wide_i` has no effect.
- R7: With `mf_sync_i`=0 and `dbl_wide_i`=1, `sync_o` stays high for bit position 1 as well as the framing bit, on signaling frames only. The signaling frames are 6 and 12 when `esf_i`=0, and 6, 12, 18 and 24 when `esf_i`=1.
- R8: With `esf_i`=1, `link_clk_o` is 1 only during the framing bit of odd-numbered frames.
- R9: With `esf_i`=0, `link_clk_o` is 1 only during the framing bit of even-numbered frames, which are the frames carrying Fs bits.
- R10: If `esf_i` changes from 1 to 0 while the frame number is above 12, the frame that follows the current one is frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1.544 MHz bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| esf_i | input | 1 | 1 = 24-frame ESF multiframe, 0 = 12-frame D4 multiframe |
| mf_sync_i | input | 1 | 1 = sync once per multiframe, 0 = sync once per frame |
| dbl_wide_i | input | 1 | Widen the per-frame sync to two bits on signaling frames |
| chan_mask_i | input | 24 | Block level per channel, bit 0 = channel 1 |
| chan_clk_o | output | 1 | Channel LSB strobe |
| chan_blk_o | output | 1 | Per-channel block output |
| sync_o | output | 1 | Frame or multiframe sync pulse |
| link_clk_o | output | 1 | Data-link demand clock |

## Verification
The hardest case to reach is a mode switch from ESF to D4 while the frame counter is already past the D4 multiframe length. Reaching it requires running through more than 12 full frames in ESF mode and then dropping `esf_i` in the middle of a frame. The bench does exactly this: it drives ESF multiframe sync up to frame 14 and clears `esf_i` at bit 50. It then checks that the next framing bit carries the multiframe sync, which shows that the counter wrapped to frame 1. For every other configuration, a table of settings is walked. Each setting runs 25 frames, one more than the longest multiframe, so that the multiframe wrap itself is covered.

// File: rtl/t1_tx_pkg.sv
package t1_tx_pkg;
  localparam int NUM_CH     = 24;
  localparam int CH_BITS    = 8;
  localparam int D4_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;
  localparam int SIG_PERIOD = 6;
endpackage

// File: rtl/t1_tx_count.sv
module t1_tx_count #(
  parameter int NUM_CH     = t1_tx_pkg::NUM_CH,
  parameter int CH_BITS    = t1_tx_pkg::CH_BITS,
  parameter int D4_FRAMES  = t1_tx_pkg::D4_FRAMES,
  parameter int ESF_FRAMES = t1_tx_pkg::ESF_FRAMES,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int BIT_W = $clog2(CH_BITS),
  localparam int FR_W = $clog2(ESF_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             esf_i,
  output logic             fbit_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [FR_W-1:0]  frame_o
);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CH_BITS - 1);
  localparam logic [FR_W-1:0]  D4_LAST  = FR_W'(D4_FRAMES - 1);
  localparam logic [FR_W-1:0]  ESF_LAST = FR_W'(ESF_FRAMES - 1);

  logic             fbit_q;
  logic [CH_W-1:0]  ch_q;
  logic [BIT_W-1:0] bit_q;
  logic [FR_W-1:0]  frame_q;
  logic [FR_W-1:0]  mf_last;

  assign mf_last = esf_i ? ESF_LAST : D4_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fbit_q  <= 1'b1;
      ch_q    <= '0;
      bit_q   <= '0;
      frame_q <= '0;
    end else if (fbit_q) begin
      fbit_q <= 1'b0;
      ch_q   <= '0;
      bit_q  <= '0;
    end else if (bit_q == BIT_LAST) begin
      bit_q <= '0;
      if (ch_q == CH_LAST) begin
        fbit_q  <= 1'b1;
        ch_q    <= '0;
        // wrap also covers a shorter multiframe selected mid-count
        frame_q <= (frame_q >= mf_last) ? '0 : frame_q + 1'b1;
      end else begin
        ch_q <= ch_q + 1'b1;
      end
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign fbit_o  = fbit_q;
  assign ch_o    = ch_q;
  assign bit_o   = bit_q;
  assign frame_o = frame_q;

  // R2
  fbit_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fbit_q |=> !fbit_q);
  // R2
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fbit_q && bit_q == BIT_LAST && ch_q == CH_LAST) |=> (fbit_q && bit_q == '0));
  // R10
  d4_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fbit_q && !esf_i && $past(!esf_i)) |-> (frame_q <= D4_LAST));
endmodule

// File: rtl/t1_tx_chan_strobe.sv
module t1_tx_chan_strobe #(
  parameter int NUM_CH  = t1_tx_pkg::NUM_CH,
  parameter int CH_BITS = t1_tx_pkg::CH_BITS,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int BIT_W = $clog2(CH_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fbit_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic              chan_clk_o,
  output logic              chan_blk_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CH_BITS - 1);

  assign chan_clk_o = !fbit_i && (bit_i == BIT_LAST);
  assign chan_blk_o = !fbit_i && mask_i[ch_i];

  // R3
  chclk_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_clk_o |=> !chan_clk_o);
  // R4
  blk_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fbit_i && bit_i != '0 && $stable(mask_i)) |-> $stable(chan_blk_o));
endmodule

// File: rtl/t1_tx_sync_link.sv
module t1_tx_sync_link #(
  parameter int NUM_CH     = t1_tx_pkg::NUM_CH,
  parameter int CH_BITS    = t1_tx_pkg::CH_BITS,
  parameter int ESF_FRAMES = t1_tx_pkg::ESF_FRAMES,
  parameter int SIG_PERIOD = t1_tx_pkg::SIG_PERIOD,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int BIT_W = $clog2(CH_BITS),
  localparam int FR_W = $clog2(ESF_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fbit_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic [FR_W-1:0]  frame_i,
  input  logic             esf_i,
  input  logic             mf_sync_i,
  input  logic             dbl_wide_i,
  output logic             sync_o,
  output logic             link_o
);
  logic sig_frame;
  logic first_bit;

  // frame_i is zero-based, so signaling frames satisfy (frame_i+1) % SIG_PERIOD == 0
  assign sig_frame = ((32'(frame_i) + 32'd1) % 32'(SIG_PERIOD)) == 32'd0;
  assign first_bit = !fbit_i && (ch_i == '0) && (bit_i == '0);

  always_comb begin
    if (mf_sync_i) sync_o = fbit_i && (frame_i == '0);
    else           sync_o = fbit_i || (dbl_wide_i && sig_frame && first_bit);
  end

  // ESF: odd frames (zero-based even); D4: even frames (zero-based odd)
  assign link_o = fbit_i && (esf_i ? !frame_i[0] : frame_i[0]);

  // R7
  dbl_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && !fbit_i) |-> $past(sync_o));
  // R8
  link_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o |=> !link_o);
  // R6
  mf_sync_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mf_sync_i && sync_o) |=> !sync_o);
endmodule

// File: rtl/t1_tx_timing.sv
module t1_tx_timing #(
  parameter int NUM_CH     = t1_tx_pkg::NUM_CH,
  parameter int CH_BITS    = t1_tx_pkg::CH_BITS,
  parameter int D4_FRAMES  = t1_tx_pkg::D4_FRAMES,
  parameter int ESF_FRAMES = t1_tx_pkg::ESF_FRAMES,
  parameter int SIG_PERIOD = t1_tx_pkg::SIG_PERIOD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              esf_i,
  input  logic              mf_sync_i,
  input  logic              dbl_wide_i,
  input  logic [NUM_CH-1:0] chan_mask_i,
  output logic              chan_clk_o,
  output logic              chan_blk_o,
  output logic              sync_o,
  output logic              link_clk_o
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int BIT_W = $clog2(CH_BITS);
  localparam int FR_W  = $clog2(ESF_FRAMES);

  logic             fbit;
  logic [CH_W-1:0]  ch;
  logic [BIT_W-1:0] bit_pos;
  logic [FR_W-1:0]  frame;

  t1_tx_count #(
    .NUM_CH(NUM_CH), .CH_BITS(CH_BITS),
    .D4_FRAMES(D4_FRAMES), .ESF_FRAMES(ESF_FRAMES)
  ) i_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .esf_i(esf_i),
    .fbit_o(fbit), .ch_o(ch), .bit_o(bit_pos), .frame_o(frame)
  );

  t1_tx_chan_strobe #(
    .NUM_CH(NUM_CH), .CH_BITS(CH_BITS)
  ) i_chan (
    .clk_i(clk_i), .rst_ni(rst_ni), .fbit_i(fbit), .ch_i(ch), .bit_i(bit_pos),
    .mask_i(chan_mask_i), .chan_clk_o(chan_clk_o), .chan_blk_o(chan_blk_o)
  );

  t1_tx_sync_link #(
    .NUM_CH(NUM_CH), .CH_BITS(CH_BITS),
    .ESF_FRAMES(ESF_FRAMES), .SIG_PERIOD(SIG_PERIOD)
  ) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .fbit_i(fbit), .ch_i(ch), .bit_i(bit_pos),
    .frame_i(frame), .esf_i(esf_i), .mf_sync_i(mf_sync_i), .dbl_wide_i(dbl_wide_i),
    .sync_o(sync_o), .link_o(link_clk_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (!chan_clk_o && !chan_blk_o));
endmodule

// File: tb/test_t1_tx_timing.sv
module test_t1_tx_timing;
  localparam int NCH = 24;
  localparam int FRAME_BITS = 193;
  localparam int RUN_FRAMES = 25;
  localparam int NVEC = 6;
  // {esf, mf_sync, dbl_wide, mask}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 24'hA5C30F},
    {1'b0, 1'b0, 1'b1, 24'hFFFFFF},
    {1'b1, 1'b0, 1'b1, 24'h000001},
    {1'b0, 1'b1, 1'b1, 24'h800000},
    {1'b1, 1'b1, 1'b0, 24'h000000},
    {1'b1, 1'b0, 1'b0, 24'h5A5A5A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic esf = 1'b0, mf = 1'b0, dw = 1'b0;
  logic [NCH-1:0] mask = '0;
  logic chan_clk, chan_blk, sync, link_clk;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  t1_tx_timing i_t1_tx_timing (
    .clk_i(clk), .rst_ni(rst_n), .esf_i(esf), .mf_sync_i(mf), .dbl_wide_i(dw),
    .chan_mask_i(mask), .chan_clk_o(chan_clk), .chan_blk_o(chan_blk),
    .sync_o(sync), .link_clk_o(link_clk)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Reset; release at a falling edge so the next sample is the framing bit of frame 1.
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic check_pos(input int p, input int f);
    logic fb, e_clk, e_blk, e_sync, e_link;
    int ch, bib;
    string stag;
    fb = (p == 0);
    ch = fb ? 0 : (p - 1) / 8;
    bib = fb ? 0 : (p - 1) % 8;
    e_clk = !fb && bib == 7;
    e_blk = !fb && mask[ch];
    if (mf) e_sync = fb && f == 1;
    else e_sync = fb || (dw && (f % 6 == 0) && p == 1);
    e_link = fb && (esf ? (f % 2 == 1) : (f % 2 == 0));
    stag = mf ? "R6" : (dw ? "R7" : "R5");
    chk("R3", chan_clk, e_clk);
    chk("R4", chan_blk, e_blk);
    chk(stag, sync, e_sync);
    chk(esf ? "R8" : "R9", link_clk, e_link);
  endtask

  initial begin
    int gap;
    for (int v = 0; v < NVEC; v++) begin
      int p, f, mflen;
      {esf, mf, dw, mask} = VEC[v];
      mflen = esf ? 24 : 12;
      do_reset();
      p = 0; f = 1;
      for (int c = 0; c < RUN_FRAMES * FRAME_BITS; c++) begin
        check_pos(p, f);
        @(negedge clk); #1;
        p++;
        if (p == FRAME_BITS) begin
          p = 0;
          f = (f == mflen) ? 1 : f + 1;
        end
      end
    end

    // R1: reset state, per-frame mode, ESF
    esf = 1'b1; mf = 1'b0; dw = 1'b0; mask = '1;
    do_reset();
    chk("R1", sync, 1'b1);
    chk("R1", chan_clk, 1'b0);
    chk("R1", chan_blk, 1'b0);
    chk("R1", link_clk, 1'b1);

    // R2: distance between framing-bit syncs
    gap = 0;
    do begin @(negedge clk); #1; gap++; end while (!sync && gap < 400);
    chk("R2", gap == FRAME_BITS, 1'b1);
    if (gap != FRAME_BITS) $display("FAIL R2: actual gap=%0d expected=%0d", gap, FRAME_BITS);

    // R10: ESF multiframe sync, switch to D4 at bit 50 of frame 14
    esf = 1'b1; mf = 1'b1; dw = 1'b0;
    do_reset();
    repeat (13 * FRAME_BITS + 50) @(negedge clk);
    #1;
    esf = 1'b0;
    repeat (FRAME_BITS - 50 - 1) begin
      @(negedge clk); #1;
      chk("R10", sync, 1'b0);
    end
    @(negedge clk); #1;
    chk("R10", sync, 1'b1);
    chk("R10", link_clk, 1'b0);
    repeat (12 * FRAME_BITS) @(negedge clk);
    #1;
    chk("R10", sync, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule